// File: doc/BRIEF.md
# SPI FIFO request and flag controller

This block keeps the status flags of a queued SPI master that feeds its shifter from two FIFOs, one for transmit data and one for commands, and turns those flags into an interrupt line and one DMA request line per FIFO. It watches the fill counts of both FIFOs, the DMA push strobes, the last-bit strobe from the shifter together with the end-of-queue and last-frame bits of the command being executed, and an extended-mode enable that decides whether the two FIFOs are filled separately. Software acknowledges flags by writing ones to a flag register and chooses the enabled requests and their routing through a configuration register.

Both fill flags refuse a software acknowledge while their FIFO still has room, so a handler that pushes one entry and acknowledges sees the flag again at once until the FIFO is full. A DMA push clears its flag for one cycle, which gives the DMA engine a request edge per transfer. In extended mode the end-of-queue event waits for the final data frame of a multi-frame command, and a data-without-command condition is raised as an invalid-write flag.

Top module: `spi_fifo_req_ctrl`

## Requirements
- R1: During and right after reset, `flags`, `irq`, `tx_dma_req` and `cmd_dma_req` are all zero. Flag bit positions: 0 end-of-queue, 1 transmit fill, 2 command fill, 3 invalid write.
- R2: One cycle after `tx_count` is below `TX_DEPTH`, flag bit 1 is set, and it stays set while the FIFO is not full.
- R3: A write with `flag_wr` high and a 1 in bit 1 of `flag_wdata` clears flag bit 1 on the next cycle only if `tx_count` equals `TX_DEPTH`; while not full the write is refused. Writing 0 to any flag bit has no effect.
- R4: A `tx_push_dma` strobe clears flag bit 1 on the next cycle; if the FIFO is still not full the flag is set again one cycle later.
- R5: Flag bit 2 follows R2 to R4 for the command FIFO (`cmd_count`, `CMD_DEPTH`, `cmd_push_dma`) when `xmode_en` is high; when `xmode_en` is low it is held at 0.
- R6: Flag bit 0 is set one cycle after a `last_bit` strobe while `cmd_eoq` is high; a strobe with `cmd_eoq` low leaves it unchanged. It is cleared by writing 1 to bit 0.
- R7: With `xmode_en` high, the end-of-queue flag is set only when `cmd_last_frame` is also high at the `last_bit` strobe.
- R8: Flag bit 3 is set one cycle after `xmode_en` is high, `tx_count` is nonzero and `cmd_count` is zero; it never sets with `xmode_en` low and is cleared by writing 1 to bit 3.
- R9: Configuration `cfg_wdata` bits 3:0 enable the request of flags 0 to 3, bit 4 routes the transmit fill request and bit 5 the command fill request to DMA when 1, to the interrupt when 0. `irq` is the OR of every enabled flag routed to interrupt (flags 0 and 3 always are); a DMA line is high only while its flag, its enable and its DMA routing are all set.
- R10: When a flag's set condition and a write-one clear of that flag fall in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xmode_en | input | 1 | Extended mode: FIFOs filled independently |
| tx_count | input | TX_CW | Entries in the transmit data FIFO |
| cmd_count | input | CMD_CW | Entries in the command FIFO |
| tx_push_dma | input | 1 | DMA pushed one transmit entry |
| cmd_push_dma | input | 1 | DMA pushed one command entry |
| last_bit | input | 1 | Last bit of the current frame shifted out |
| cmd_eoq | input | 1 | End-of-queue bit of the executing command |
| cmd_last_frame | input | 1 | Current frame is the final one of its command |
| flag_wr | input | 1 | Write strobe for the flag register |
| flag_wdata | input | 4 | Write-one-to-clear data for the flags |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 6 | Enables (3:0) and DMA routing (5:4) |
| flags | output | 4 | Current flags |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | Transmit FIFO DMA request |
| cmd_dma_req | output | 1 | Command FIFO DMA request |

## Verification
A flag register stuck or mis-sequenced shows on `flags` one cycle after the causing strobe or count change, and on `irq` or a DMA line in that same cycle once the request is enabled, because the routing is combinational from the registers. A clear that is wrongly accepted while the FIFO has room shows as a flag low the cycle after the write, and a DMA push that fails to drop its flag shows as no one-cycle gap. A wrong extended-mode gate shows as an end-of-queue or invalid-write flag that rises when it should stay low, or a command fill flag outside extended mode.

// File: rtl/spi_req_pkg.sv
// Shared flag positions and configuration layout for the SPI request controller.
// Assumes four flags; positions are fixed because software decodes them.
package spi_req_pkg;
    localparam int FLG_EOQ  = 0;
    localparam int FLG_TXF  = 1;
    localparam int FLG_CMDF = 2;
    localparam int FLG_INV  = 3;
    localparam int NFLAGS   = 4;

    typedef struct packed {
        logic              cmd_to_dma;
        logic              tx_to_dma;
        logic [NFLAGS-1:0] req_en;
    } req_cfg_t;
endpackage

// File: rtl/spi_fill_flag.sv
// FIFO room flag: sets while the FIFO is below DEPTH, is dropped for one
// cycle by a DMA push, and accepts a software clear only when the FIFO is full.
// Assumes count never exceeds DEPTH. Held clear while 'active' is low.
module spi_fill_flag #(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [CW-1:0] count,
    input  logic          dma_push,
    input  logic          sw_clr,
    output logic          flag
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic has_room;

    // Room exists when the count is below the depth.
    always_comb has_room = (count < FULL);

    // Flag state: DMA clear first, then room sets, then a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (!active)   flag <= 1'b0;
        else if (dma_push)  flag <= 1'b0;
        else if (has_room)  flag <= 1'b1;
        else if (sw_clr)    flag <= 1'b0;
    end
endmodule

// File: rtl/spi_event_flag.sv
// Sticky event flag: a set pulse makes it 1, a write-one clear makes it 0,
// and a set in the same cycle as a clear wins.
module spi_event_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic sw_clr,
    output logic flag
);
    // Sticky state with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_ev)  flag <= 1'b1;
        else if (sw_clr)  flag <= 1'b0;
    end
endmodule

// File: rtl/spi_req_router.sv
// Combines flags with the configuration into the interrupt and DMA lines.
// Flags without a routing bit always go to the interrupt.
module spi_req_router
    import spi_req_pkg::*;
(
    input  logic [NFLAGS-1:0] flags,
    input  req_cfg_t          cfg,
    output logic              irq,
    output logic              tx_dma_req,
    output logic              cmd_dma_req
);
    logic [NFLAGS-1:0] live;
    logic [NFLAGS-1:0] to_dma;

    // Per-flag routing: only the two fill flags may go to DMA.
    always_comb begin
        live            = flags & cfg.req_en;
        to_dma          = '0;
        to_dma[FLG_TXF]  = cfg.tx_to_dma;
        to_dma[FLG_CMDF] = cfg.cmd_to_dma;
    end

    // Output lines from the enabled flags.
    always_comb begin
        irq         = |(live & ~to_dma);
        tx_dma_req  = live[FLG_TXF]  & to_dma[FLG_TXF];
        cmd_dma_req = live[FLG_CMDF] & to_dma[FLG_CMDF];
    end
endmodule

// File: rtl/spi_fifo_req_ctrl.sv
// Flag and request controller for a queued SPI master with separate data and
// command FIFOs. Holds the configuration register, the four flags and the
// request routing. Assumes the FIFO counts and strobes are synchronous to clk.
module spi_fifo_req_ctrl
    import spi_req_pkg::*;
#(
    parameter int TX_DEPTH  = 8,
    parameter int CMD_DEPTH = 8,
    parameter int TX_CW     = $clog2(TX_DEPTH + 1),
    parameter int CMD_CW    = $clog2(CMD_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xmode_en,
    input  logic [TX_CW-1:0]  tx_count,
    input  logic [CMD_CW-1:0] cmd_count,
    input  logic              tx_push_dma,
    input  logic              cmd_push_dma,
    input  logic              last_bit,
    input  logic              cmd_eoq,
    input  logic              cmd_last_frame,
    input  logic              flag_wr,
    input  logic [3:0]        flag_wdata,
    input  logic              cfg_wr,
    input  logic [5:0]        cfg_wdata,
    output logic [3:0]        flags,
    output logic              irq,
    output logic              tx_dma_req,
    output logic              cmd_dma_req
);
    req_cfg_t          cfg_q;
    logic [NFLAGS-1:0] clr;
    logic              eoq_set;
    logic              inv_set;

    // Configuration register, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= req_cfg_t'(cfg_wdata);
    end

    // Decode the write-one-to-clear strobes and the event set conditions.
    always_comb begin
        clr     = flag_wr ? flag_wdata : '0;
        eoq_set = last_bit && cmd_eoq && (!xmode_en || cmd_last_frame);
        inv_set = xmode_en && (tx_count != '0) && (cmd_count == '0);
    end

    spi_event_flag u_eoq (
        .clk(clk), .rst_n(rst_n), .set_ev(eoq_set),
        .sw_clr(clr[FLG_EOQ]), .flag(flags[FLG_EOQ])
    );

    spi_event_flag u_inv (
        .clk(clk), .rst_n(rst_n), .set_ev(inv_set),
        .sw_clr(clr[FLG_INV]), .flag(flags[FLG_INV])
    );

    spi_fill_flag #(.DEPTH(TX_DEPTH), .CW(TX_CW)) u_txf (
        .clk(clk), .rst_n(rst_n), .active(1'b1), .count(tx_count),
        .dma_push(tx_push_dma), .sw_clr(clr[FLG_TXF]), .flag(flags[FLG_TXF])
    );

    spi_fill_flag #(.DEPTH(CMD_DEPTH), .CW(CMD_CW)) u_cmdf (
        .clk(clk), .rst_n(rst_n), .active(xmode_en), .count(cmd_count),
        .dma_push(cmd_push_dma), .sw_clr(clr[FLG_CMDF]), .flag(flags[FLG_CMDF])
    );

    spi_req_router u_route (
        .flags(flags), .cfg(cfg_q), .irq(irq),
        .tx_dma_req(tx_dma_req), .cmd_dma_req(cmd_dma_req)
    );
endmodule

// File: rtl/spi_fifo_req_ctrl_chk.sv
// Port-level checker for the SPI request controller, bound to every instance.
module spi_fifo_req_ctrl_chk #(
    parameter int TX_DEPTH  = 8,
    parameter int CMD_DEPTH = 8,
    parameter int TX_CW     = 4,
    parameter int CMD_CW    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xmode_en,
    input logic [TX_CW-1:0]  tx_count,
    input logic [CMD_CW-1:0] cmd_count,
    input logic              tx_push_dma,
    input logic              cmd_push_dma,
    input logic              last_bit,
    input logic              cmd_eoq,
    input logic [3:0]        flags,
    input logic              tx_dma_req,
    input logic              cmd_dma_req
);
    AST_TX_ROOM_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count < TX_CW'(TX_DEPTH) && !tx_push_dma) |=> flags[1]); // R3
    AST_TX_DMA_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push_dma |=> !flags[1]); // R4
    AST_CMD_IDLE_OUTSIDE_XMODE: assert property (@(posedge clk) disable iff (!rst_n)
        !xmode_en |=> !flags[2]); // R5
    AST_CMD_ROOM_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (xmode_en && cmd_count < CMD_CW'(CMD_DEPTH) && !cmd_push_dma) |=> flags[2]); // R5
    AST_EOQ_NEEDS_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(last_bit && cmd_eoq)); // R6
    AST_INV_NEEDS_XMODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[3]) |-> $past(xmode_en)); // R8
    AST_TX_DMA_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> flags[1]); // R9
    AST_CMD_DMA_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_dma_req |-> flags[2]); // R9
endmodule

bind spi_fifo_req_ctrl spi_fifo_req_ctrl_chk #(
    .TX_DEPTH(TX_DEPTH), .CMD_DEPTH(CMD_DEPTH), .TX_CW(TX_CW), .CMD_CW(CMD_CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .xmode_en(xmode_en), .tx_count(tx_count),
    .cmd_count(cmd_count), .tx_push_dma(tx_push_dma), .cmd_push_dma(cmd_push_dma),
    .last_bit(last_bit), .cmd_eoq(cmd_eoq), .flags(flags),
    .tx_dma_req(tx_dma_req), .cmd_dma_req(cmd_dma_req)
);

// File: tb/spi_fifo_req_ctrl_tb.sv
// Directed bench for the SPI request controller: one task per scenario.
module spi_fifo_req_ctrl_tb;
    localparam int D  = 8;
    localparam int CW = 4;
    localparam int B_EOQ = 0, B_TXF = 1, B_CMDF = 2, B_INV = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xmode_en = 1'b0;
    logic [CW-1:0] tx_count = CW'(D);
    logic [CW-1:0] cmd_count = CW'(D);
    logic          tx_push_dma = 1'b0, cmd_push_dma = 1'b0;
    logic          last_bit = 1'b0, cmd_eoq = 1'b0, cmd_last_frame = 1'b0;
    logic          flag_wr = 1'b0;
    logic [3:0]    flag_wdata = '0;
    logic          cfg_wr = 1'b0;
    logic [5:0]    cfg_wdata = '0;
    logic [3:0]    flags;
    logic          irq, tx_dma_req, cmd_dma_req;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spi_fifo_req_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .xmode_en(xmode_en), .tx_count(tx_count),
        .cmd_count(cmd_count), .tx_push_dma(tx_push_dma), .cmd_push_dma(cmd_push_dma),
        .last_bit(last_bit), .cmd_eoq(cmd_eoq), .cmd_last_frame(cmd_last_frame),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .flags(flags), .irq(irq), .tx_dma_req(tx_dma_req), .cmd_dma_req(cmd_dma_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock; inputs change and outputs are read 1 ns after the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_flags(input logic [3:0] v);
        flag_wr = 1'b1; flag_wdata = v;
        step();
        flag_wr = 1'b0; flag_wdata = '0;
    endtask

    task automatic wr_cfg(input logic [5:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 flags in reset", int'(flags), 0);
        check("R1 irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        step();
        check("R1 flags after reset", int'(flags), 0);
        check("R1 dma lines after reset", int'({tx_dma_req, cmd_dma_req}), 0);
    endtask

    task automatic t_tx_fill();
        tx_count = 3;
        step();
        check("R2 tx fill sets", int'(flags[B_TXF]), 1);
        wr_flags(4'b0010);
        check("R3 clear refused while room", int'(flags[B_TXF]), 1);
        tx_count = CW'(D);
        step();
        check("R2 flag held when full", int'(flags[B_TXF]), 1);
        wr_flags(4'b0000);
        check("R3 write of 0 ignored", int'(flags[B_TXF]), 1);
        wr_flags(4'b0010);
        check("R3 clear accepted when full", int'(flags[B_TXF]), 0);
    endtask

    task automatic t_tx_dma();
        tx_count = 5;
        step();
        tx_push_dma = 1'b1;
        step();
        tx_push_dma = 1'b0;
        check("R4 dma push drops flag", int'(flags[B_TXF]), 0);
        step();
        check("R4 flag returns with room", int'(flags[B_TXF]), 1);
    endtask

    task automatic t_route();
        wr_cfg(6'b00_0010);
        check("R9 tx fill to irq", int'({irq, tx_dma_req}), 2);
        wr_cfg(6'b01_0010);
        check("R9 tx fill to dma", int'({irq, tx_dma_req}), 1);
        wr_cfg(6'b01_0000);
        check("R9 disabled request quiet", int'({irq, tx_dma_req}), 0);
        tx_count = CW'(D);
        step();
        wr_flags(4'b0010);
    endtask

    task automatic t_cmd_inv();
        cmd_count = 2;
        step();
        check("R5 cmd flag idle outside xmode", int'(flags[B_CMDF]), 0);
        xmode_en = 1'b1;
        step();
        check("R5 cmd flag sets in xmode", int'(flags[B_CMDF]), 1);
        wr_cfg(6'b10_0100);
        check("R9 cmd dma request", int'({cmd_dma_req, irq}), 2);
        wr_flags(4'b0100);
        check("R5 cmd clear refused", int'(flags[B_CMDF]), 1);
        cmd_push_dma = 1'b1;
        step();
        cmd_push_dma = 1'b0;
        check("R5 cmd dma push drops flag", int'(flags[B_CMDF]), 0);
        wr_cfg(6'b00_0000);
        tx_count = 5;
        step();
        check("R8 no invalid write with command", int'(flags[B_INV]), 0);
        cmd_count = 0;
        step();
        check("R8 invalid write sets", int'(flags[B_INV]), 1);
        wr_flags(4'b1000);
        check("R10 set wins over clear", int'(flags[B_INV]), 1);
        xmode_en = 1'b0;
        step();
        check("R5 cmd flag dropped outside xmode", int'(flags[B_CMDF]), 0);
        wr_flags(4'b1000);
        check("R8 cleared, not set outside xmode", int'(flags[B_INV]), 0);
        tx_count = CW'(D); cmd_count = CW'(D);
        step();
        wr_flags(4'b0010);
    endtask

    task automatic t_eoq();
        last_bit = 1'b1; cmd_eoq = 1'b0;
        step();
        last_bit = 1'b0;
        check("R6 no eoq without bit", int'(flags[B_EOQ]), 0);
        last_bit = 1'b1; cmd_eoq = 1'b1;
        step();
        last_bit = 1'b0; cmd_eoq = 1'b0;
        check("R6 eoq sets at last bit", int'(flags[B_EOQ]), 1);
        wr_cfg(6'b00_0001);
        check("R9 eoq irq", int'(irq), 1);
        wr_flags(4'b0001);
        check("R6 eoq cleared", int'(flags[B_EOQ]), 0);
        last_bit = 1'b1; cmd_eoq = 1'b1; flag_wr = 1'b1; flag_wdata = 4'b0001;
        step();
        last_bit = 1'b0; cmd_eoq = 1'b0; flag_wr = 1'b0; flag_wdata = '0;
        check("R10 eoq set beats clear", int'(flags[B_EOQ]), 1);
        wr_flags(4'b0001);
        xmode_en = 1'b1;
        last_bit = 1'b1; cmd_eoq = 1'b1; cmd_last_frame = 1'b0;
        step();
        check("R7 eoq held until last frame", int'(flags[B_EOQ]), 0);
        cmd_last_frame = 1'b1;
        step();
        last_bit = 1'b0; cmd_eoq = 1'b0; cmd_last_frame = 1'b0;
        check("R7 eoq at last frame", int'(flags[B_EOQ]), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_tx_fill();
        t_tx_dma();
        t_route();
        t_cmd_inv();
        t_eoq();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule